// File: doc/BRIEF.md
# Dependent-Slice Redispatch Controller

This block sits beside a small reorder buffer. It records, for every in-flight micro-op, which older micro-ops it took values from, whether directly or through a chain of other consumers. When a micro-op turns out to have been executed on wrong speculative data, the block works out the set of consumers that inherited the bad value. It pulls them out of whatever state they had reached and hands them back to the issue queue one at a time, oldest first, ahead of any ordinary ready work. The reporter chooses whether the faulty micro-op goes back with its consumers or stays as it is. Leaving it out suits the case where the correct value can be written into its result directly.

A stall monitor guards against the case where redispatched work and unrelated work block each other in the issue queue. If ready work exists but nothing has dispatched for a fixed number of cycles, the block raises a one-cycle flush request and returns every entry to the free state.

Allocation and the priority hand-off are valid/ready streams. An allocation is taken only when `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low while a slice is being handed out, in the flush cycle, and in any cycle that carries a mis-speculation report. The priority stream presents one entry index while `pri_valid` is high. That index holds steady until the cycle in which `pri_ready` is high, and the stream then moves to the next-oldest pending entry. Dispatch, completion and reports are plain strobes.

Top module: `slice_redispatch`

## Requirements
- R1: An accepted allocation places the entry in the ready state, visible in `rdy_vec` from the next cycle. `alloc_ready` equals NOT `busy` AND NOT `flush_req` AND NOT `ms_valid`.
- R2: A dispatch strobe moves a ready entry to the issued state, so its bit in `rdy_vec` clears. A completion strobe moves an issued entry to done, so its bit in `done_vec` sets. A strobe naming an entry in any other state is ignored, and so is a dispatch strobe while `busy` is high.
- R3: An entry belongs to the slice of a report on entry M when M is among its producers, directly or through any chain of live producers. Each producer is named by a source index and a source-valid bit at allocation. A source naming a free entry, or the entry being allocated, is ignored.
- R4: With `ms_incl` low, entry M keeps its current state and is not handed out. With `ms_incl` high, entry M joins the slice.
- R5: Slice entries appear on `pri_idx` oldest first, ordered by allocation, each exactly once. The index holds while `pri_ready` is low. After its handshake an entry is ready again.
- R6: At an accepted report, every slice entry leaves the issued or done state, so its `done_vec` bit is clear from the next cycle.
- R7: `busy` is high from the cycle after an accepted report with a non-empty slice until the last slice handshake. Reports arriving while `busy` is high are ignored. A report with an empty slice leaves `busy` low.
- R8: While `busy` is high, `rdy_vec` reads all zeros, so ordinary ready entries wait behind the slice.
- R9: `flush_req` rises after 64 consecutive cycles in which some entry is ready or pending redispatch and no dispatch is accepted. An accepted dispatch, or a cycle with no such entry, restarts the count.
- R10: In the cycle after `flush_req` is high, every entry is free. `rdy_vec` and `done_vec` are zero and `busy` and `flush_req` are low.
- R11: Allocating into a slot cuts every recorded dependence on the slot's previous occupant. A later report on the new occupant does not reach consumers of the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation offered |
| alloc_ready | output | 1 | Allocation can be taken this cycle |
| alloc_idx | input | IW | Slot receiving the new micro-op |
| alloc_src_vld | input | NSRC | Per-source valid bits |
| alloc_src_idx | input | NSRC*IW | Producer slot per source, source 0 in the low bits |
| disp_valid | input | 1 | Issue queue accepted an entry |
| disp_idx | input | IW | Entry accepted |
| cpl_valid | input | 1 | Entry finished execution |
| cpl_idx | input | IW | Entry finished |
| ms_valid | input | 1 | Mis-speculation report |
| ms_idx | input | IW | Mis-speculated entry |
| ms_incl | input | 1 | Also redispatch the reported entry |
| busy | output | 1 | Slice hand-out in progress |
| rdy_vec | output | ENTRIES | Entries ready for ordinary dispatch |
| done_vec | output | ENTRIES | Entries in the done state |
| pri_valid | output | 1 | Priority entry offered |
| pri_ready | input | 1 | Issue queue takes the priority entry |
| pri_idx | output | IW | Priority entry index |
| flush_req | output | 1 | Full pipeline flush request |

## Verification
The assertions rely on only two things about the inputs: they hold known values after reset, and `pri_ready` may stall for any number of cycles. The properties on ordering, the dependence bitmaps and the stall counter hold for any mix of strobes, including strobes that name free or wrongly-stated entries. The random stimulus draws every index from the full slot range. It aims dispatch and completion mostly at entries in the right state but sometimes at arbitrary ones, and it offers allocations even when `alloc_ready` is low. Periodic windows with no dispatch drive the stall monitor to its limit.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [2:0] {
    ST_FREE   = 3'd0,
    ST_READY  = 3'd1,
    ST_ISSUED = 3'd2,
    ST_DONE   = 3'd3,
    ST_WAIT   = 3'd4
  } ent_st_e;
endpackage

// File: rtl/srd_age_track.sv
module srd_age_track #(
  parameter int ENTRIES = 8,
  parameter int IW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               alloc_en,
  input  logic [IW-1:0]      alloc_idx,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] cand,
  output logic [ENTRIES-1:0] pick_oh,
  output logic [IW-1:0]      pick_idx
);
  // older_q[e][j] set: entry j was allocated before entry e
  logic [ENTRIES-1:0] older_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) older_q[e] <= '0;
    end else if (clr) begin
      for (int e = 0; e < ENTRIES; e++) older_q[e] <= '0;
    end else if (alloc_en) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (IW'(e) == alloc_idx)
          older_q[e] <= live & ~(ENTRIES'(1) << e);
        else
          older_q[e][alloc_idx] <= 1'b0;
      end
    end
  end

  // oldest candidate: no other candidate is older than it
  always_comb begin
    pick_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      pick_oh[e] = cand[e] && ((older_q[e] & cand) == '0);
      if (pick_oh[e]) pick_idx = IW'(e);
    end
  end

  // R5
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));

  for (genvar a = 0; a < ENTRIES; a++) begin : g_row
    for (genvar b = a + 1; b < ENTRIES; b++) begin : g_col
      // R5
      age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(older_q[a][b] && older_q[b][a]));
    end
  end
endmodule

// File: rtl/srd_dep_table.sv
module srd_dep_table #(
  parameter int ENTRIES = 8,
  parameter int IW      = 3,
  parameter int NSRC    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               alloc_en,
  input  logic [IW-1:0]      alloc_idx,
  input  logic [NSRC-1:0]    src_vld,
  input  logic [NSRC*IW-1:0] src_idx,
  input  logic [ENTRIES-1:0] live,
  input  logic [IW-1:0]      probe_idx,
  output logic [ENTRIES-1:0] slice_vec
);
  // dep_q[e][p] set: entry e inherits a value from entry p (any depth)
  logic [ENTRIES-1:0] dep_q [ENTRIES];
  logic [ENTRIES-1:0] row_new;

  always_comb begin
    logic [IW-1:0] sidx;
    row_new = '0;
    for (int s = 0; s < NSRC; s++) begin
      sidx = src_idx[s*IW +: IW];
      if (src_vld[s] && live[sidx] && (sidx != alloc_idx))
        row_new = row_new | dep_q[sidx] | (ENTRIES'(1) << sidx);
    end
    row_new = row_new & ~(ENTRIES'(1) << alloc_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) dep_q[e] <= '0;
    end else if (clr) begin
      for (int e = 0; e < ENTRIES; e++) dep_q[e] <= '0;
    end else if (alloc_en) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (IW'(e) == alloc_idx)
          dep_q[e] <= row_new;
        else
          dep_q[e][alloc_idx] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) slice_vec[e] = dep_q[e][probe_idx];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_diag
    // R3
    no_self_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dep_q[e][e]);
  end
endmodule

// File: rtl/srd_watchdog.sv
module srd_watchdog #(
  parameter int LIMIT = 64,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  input  logic progress,
  output logic flush_req
);
  logic [CW-1:0] cnt_q;

  assign flush_req = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (flush_req || progress || !stall)
      cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))
      cnt_q <= cnt_q + CW'(1);
  end

  // R9
  wd_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

  // R10
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);
endmodule

// File: rtl/slice_redispatch.sv
module slice_redispatch
  import srd_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int NSRC        = 2,
  parameter int STALL_LIMIT = 64,
  localparam int IW         = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  output logic               alloc_ready,
  input  logic [IW-1:0]      alloc_idx,
  input  logic [NSRC-1:0]    alloc_src_vld,
  input  logic [NSRC*IW-1:0] alloc_src_idx,
  input  logic               disp_valid,
  input  logic [IW-1:0]      disp_idx,
  input  logic               cpl_valid,
  input  logic [IW-1:0]      cpl_idx,
  input  logic               ms_valid,
  input  logic [IW-1:0]      ms_idx,
  input  logic               ms_incl,
  output logic               busy,
  output logic [ENTRIES-1:0] rdy_vec,
  output logic [ENTRIES-1:0] done_vec,
  output logic               pri_valid,
  input  logic               pri_ready,
  output logic [IW-1:0]      pri_idx
  ,output logic              flush_req
);
  ent_st_e st_q [ENTRIES];
  ent_st_e st_n [ENTRIES];

  logic [ENTRIES-1:0] live, rdy_bits, wait_bits, slice_vec, pick_oh;
  logic alloc_fire, ms_acc, disp_acc, stall;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      live[e]      = (st_q[e] != ST_FREE);
      rdy_bits[e]  = (st_q[e] == ST_READY);
      wait_bits[e] = (st_q[e] == ST_WAIT);
      done_vec[e]  = (st_q[e] == ST_DONE);
    end
  end

  assign busy        = |wait_bits;
  assign pri_valid   = busy;
  assign rdy_vec     = busy ? '0 : rdy_bits;
  assign alloc_ready = !busy && !flush_req && !ms_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign ms_acc      = ms_valid && !busy && !flush_req;
  assign disp_acc    = disp_valid && !busy && !flush_req && (st_q[disp_idx] == ST_READY);
  assign stall       = |(rdy_bits | wait_bits);

  srd_age_track #(.ENTRIES(ENTRIES), .IW(IW)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flush_req),
    .alloc_en (alloc_fire),
    .alloc_idx(alloc_idx),
    .live     (live),
    .cand     (wait_bits),
    .pick_oh  (pick_oh),
    .pick_idx (pri_idx)
  );

  srd_dep_table #(.ENTRIES(ENTRIES), .IW(IW), .NSRC(NSRC)) u_dep (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flush_req),
    .alloc_en (alloc_fire),
    .alloc_idx(alloc_idx),
    .src_vld  (alloc_src_vld),
    .src_idx  (alloc_src_idx),
    .live     (live),
    .probe_idx(ms_idx),
    .slice_vec(slice_vec)
  );

  srd_watchdog #(.LIMIT(STALL_LIMIT)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .progress (disp_acc),
    .flush_req(flush_req)
  );

  // later updates take precedence: report over dispatch/completion, allocation over all
  always_comb begin
    st_n = st_q;
    if (cpl_valid && st_q[cpl_idx] == ST_ISSUED) st_n[cpl_idx] = ST_DONE;
    if (disp_acc) st_n[disp_idx] = ST_ISSUED;
    if (pri_valid && pri_ready) st_n[pri_idx] = ST_READY;
    if (ms_acc) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (live[e] && (slice_vec[e] || (ms_incl && IW'(e) == ms_idx)))
          st_n[e] = ST_WAIT;
      end
    end
    if (alloc_fire) st_n[alloc_idx] = ST_READY;
    if (flush_req) begin
      for (int e = 0; e < ENTRIES; e++) st_n[e] = ST_FREE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) st_q[e] <= ST_FREE;
    end else begin
      st_q <= st_n;
    end
  end

  // R5
  pri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_valid && !pri_ready && !flush_req) |=> (pri_valid && $stable(pri_idx)));

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ms_valid));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (rdy_vec == '0 && done_vec == '0 && !busy));
endmodule

// File: tb/slice_redispatch_bench.sv
module slice_redispatch_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, disp_valid = 0, cpl_valid = 0, ms_valid = 0, ms_incl = 0, pri_ready = 0;
  logic [2:0] alloc_idx = 0, disp_idx = 0, cpl_idx = 0, ms_idx = 0;
  logic [1:0] alloc_src_vld = 0;
  logic [5:0] alloc_src_idx = 0;
  logic alloc_ready, busy, pri_valid, flush_req;
  logic [N-1:0] rdy_vec, done_vec;
  logic [2:0] pri_idx;

  always #5 clk = ~clk;

  slice_redispatch u_slice_redispatch (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .alloc_src_vld(alloc_src_vld), .alloc_src_idx(alloc_src_idx),
    .disp_valid(disp_valid), .disp_idx(disp_idx),
    .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
    .ms_valid(ms_valid), .ms_idx(ms_idx), .ms_incl(ms_incl),
    .busy(busy), .rdy_vec(rdy_vec), .done_vec(done_vec),
    .pri_valid(pri_valid), .pri_ready(pri_ready), .pri_idx(pri_idx),
    .flush_req(flush_req)
  );

  int n_chk = 0, n_fail = 0;
  // model: 0 free, 1 ready, 2 issued, 3 done, 4 pending redispatch
  int st_m [N];
  logic [N-1:0] dep_m [N];
  int seq_m [N];
  int seqc = 0, wd_m = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_busy();
    for (int e = 0; e < N; e++) if (st_m[e] == 4) return 1;
    return 0;
  endfunction

  function automatic int m_oldest_wait();
    int best = -1;
    for (int e = 0; e < N; e++)
      if (st_m[e] == 4 && (best < 0 || seq_m[e] < seq_m[best])) best = e;
    return best < 0 ? 0 : best;
  endfunction

  function automatic int m_rdy();
    int v = 0;
    if (m_busy()) return 0;
    for (int e = 0; e < N; e++) if (st_m[e] == 1) v |= (1 << e);
    return v;
  endfunction

  function automatic int m_done();
    int v = 0;
    for (int e = 0; e < N; e++) if (st_m[e] == 3) v |= (1 << e);
    return v;
  endfunction

  task automatic model_step();
    int nst [N];
    logic [N-1:0] ndep [N];
    logic [N-1:0] d;
    bit bz, stl, dacc;
    int a, si;
    if (wd_m == 64) begin
      for (int e = 0; e < N; e++) st_m[e] = 0;
      wd_m = 0;
      return;
    end
    bz = m_busy();
    stl = 0;
    for (int e = 0; e < N; e++) if (st_m[e] == 1 || st_m[e] == 4) stl = 1;
    dacc = disp_valid && !bz && st_m[disp_idx] == 1;
    nst = st_m;
    ndep = dep_m;
    if (cpl_valid && st_m[cpl_idx] == 2) nst[cpl_idx] = 3;
    if (dacc) nst[disp_idx] = 2;
    if (bz && pri_ready) nst[m_oldest_wait()] = 1;
    if (ms_valid && !bz)
      for (int e = 0; e < N; e++)
        if (st_m[e] != 0 && (dep_m[e][ms_idx] || (ms_incl && e == int'(ms_idx)))) nst[e] = 4;
    if (alloc_valid && !bz && !ms_valid) begin
      a = alloc_idx;
      d = '0;
      for (int s = 0; s < 2; s++) begin
        si = alloc_src_idx[s*3 +: 3];
        if (alloc_src_vld[s] && st_m[si] != 0 && si != a) d = d | dep_m[si] | N'(1 << si);
      end
      d[a] = 1'b0;
      for (int e = 0; e < N; e++) ndep[e][a] = 1'b0;
      ndep[a] = d;
      nst[a] = 1;
      seq_m[a] = seqc++;
    end
    if (dacc) wd_m = 0;
    else if (stl) wd_m = (wd_m < 64) ? wd_m + 1 : 64;
    else wd_m = 0;
    st_m = nst;
    dep_m = ndep;
  endtask

  task automatic compare_all();
    bit bz = m_busy();
    check("R8", "rdy_vec", int'(rdy_vec), m_rdy());
    check("R6", "done_vec", int'(done_vec), m_done());
    check("R7", "busy", int'(busy), int'(bz));
    check("R5", "pri_valid", int'(pri_valid), int'(bz));
    if (bz) check("R5", "pri_idx", int'(pri_idx), m_oldest_wait());
    check("R9", "flush_req", int'(flush_req), int'(wd_m == 64));
    check("R1", "alloc_ready", int'(alloc_ready), int'(!bz && wd_m != 64 && !ms_valid));
  endtask

  task automatic idle();
    alloc_valid = 0; disp_valid = 0; cpl_valid = 0; ms_valid = 0; ms_incl = 0; pri_ready = 0;
    alloc_src_vld = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_alloc(input int idx, input int v0, input int s0, input int v1, input int s1);
    idle();
    alloc_valid = 1; alloc_idx = 3'(idx);
    alloc_src_vld = {1'(v1), 1'(v0)};
    alloc_src_idx = {3'(s1), 3'(s0)};
    tick();
    idle();
  endtask

  task automatic report(input int idx, input int incl);
    idle();
    ms_valid = 1; ms_idx = 3'(idx); ms_incl = 1'(incl);
    tick();
    idle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic drive_random(input int c);
    int cand [N];
    int nc;
    bit bz = m_busy();
    idle();
    if (bz) begin
      pri_ready = ($urandom % 3) != 0;
      if ($urandom % 8 == 0) begin ms_valid = 1; ms_idx = 3'($urandom % N); end
    end else if ($urandom % 100 < 8) begin
      ms_valid = 1; ms_idx = 3'($urandom % N); ms_incl = 1'($urandom % 2);
    end else if ($urandom % 100 < 45) begin
      alloc_valid = 1; alloc_idx = 3'($urandom % N);
      alloc_src_vld = 2'($urandom % 4);
      alloc_src_idx = 6'($urandom % 64);
    end
    if ((c % 700) < 600 && $urandom % 2 == 0) begin
      nc = 0;
      for (int e = 0; e < N; e++) if (st_m[e] == 1) cand[nc++] = e;
      disp_valid = 1;
      disp_idx = (nc > 0 && $urandom % 5 != 0) ? 3'(cand[$urandom % nc]) : 3'($urandom % N);
    end
    if ($urandom % 2 == 0) begin
      nc = 0;
      for (int e = 0; e < N; e++) if (st_m[e] == 2) cand[nc++] = e;
      cpl_valid = 1;
      cpl_idx = (nc > 0 && $urandom % 5 != 0) ? 3'(cand[$urandom % nc]) : 3'($urandom % N);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int exp_seq [4];
    void'($urandom(32'h5eed_0017));
    for (int e = 0; e < N; e++) begin st_m[e] = 0; dep_m[e] = '0; seq_m[e] = 0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state (R1, R10 idle values)
    check("R1", "reset rdy_vec", int'(rdy_vec), 0);
    check("R1", "reset alloc_ready", int'(alloc_ready), 1);
    check("R7", "reset busy", int'(busy), 0);
    check("R9", "reset flush_req", int'(flush_req), 0);
    compare_all();

    // chain: 6 <- 1 <- 4 ; 0 ; 3 <- {0,4}
    do_alloc(6, 0, 0, 0, 0);
    do_alloc(1, 1, 6, 0, 0);
    do_alloc(4, 1, 1, 0, 0);
    do_alloc(0, 0, 0, 0, 0);
    do_alloc(3, 1, 0, 1, 4);
    check("R1", "rdy after allocs", int'(rdy_vec), 8'b0101_1011);
    disp_valid = 1; disp_idx = 3'd4; tick(); idle();
    check("R2", "dispatched 4 leaves rdy", int'(rdy_vec[4]), 0);
    cpl_valid = 1; cpl_idx = 3'd4; tick(); idle();
    check("R2", "completed 4 in done_vec", int'(done_vec[4]), 1);
    cpl_valid = 1; cpl_idx = 3'd0; tick(); idle();
    check("R2", "completion of ready entry ignored", int'(done_vec[0]), 0);

    // exclusive report on 1: slice {4,3}, 4 older
    report(1, 0);
    check("R6", "done cleared on 4", int'(done_vec[4]), 0);
    check("R7", "busy after report", int'(busy), 1);
    check("R8", "rdy masked while busy", int'(rdy_vec), 0);
    check("R5", "first slice entry", int'(pri_idx), 4);
    tick();
    check("R5", "held under backpressure", int'(pri_idx), 4);
    pri_ready = 1; tick();
    check("R3", "second slice entry", int'(pri_idx), 3);
    tick(); idle();
    check("R7", "busy ends", int'(busy), 0);
    check("R4", "exclusive leaves 1 ready", int'(rdy_vec[1]), 1);
    check("R5", "slice returns ready", int'(rdy_vec), 8'b0101_1011);

    // inclusive report on 6: 6,1,4,3; report on 0 while busy is ignored
    report(6, 1);
    exp_seq = '{6, 1, 4, 3};
    for (int k = 0; k < 4; k++) begin
      check("R4", "inclusive order", int'(pri_idx), exp_seq[k]);
      pri_ready = 1;
      if (k == 0) begin ms_valid = 1; ms_idx = 3'd0; ms_incl = 1; end
      tick(); idle();
    end
    check("R7", "ignored report leaves no slice", int'(busy), 0);

    // reuse slot 1: old consumers detached
    do_alloc(1, 0, 0, 0, 0);
    report(1, 0);
    check("R11", "no slice through old occupant", int'(busy), 0);
    report(6, 0);
    check("R11", "slice of 6 starts at 4", int'(pri_idx), 4);
    pri_ready = 1; tick();
    check("R11", "slice of 6 then 3", int'(pri_idx), 3);
    tick(); idle();
    check("R11", "new occupant not reached", int'(busy), 0);

    // stall monitor: dispatch once, then 64 idle cycles
    disp_valid = 1; disp_idx = 3'd0; tick(); idle();
    for (int k = 1; k <= 63; k++) tick();
    check("R9", "no flush at 63", int'(flush_req), 0);
    tick();
    check("R9", "flush at 64", int'(flush_req), 1);
    tick();
    check("R10", "rdy clear after flush", int'(rdy_vec), 0);
    check("R10", "flush drops", int'(flush_req), 0);
    check("R10", "busy clear after flush", int'(busy), 0);

    for (int c = 0; c < 5000; c++) begin
      drive_random(c);
      tick();
    end
    idle();
    summary();
    $finish;
  end
endmodule